// File: doc/BRIEF.md
# SMBus Bus Timeout Monitor

This block sits next to an I2C/SMBus controller and watches the two bus lines. It keeps four separate timeout measures. Two measure how long the lines stay in one state: both lines high long enough means the bus is idle and free, and clock high with data low means the bus is stuck. The other two add up the cycles in which this node stretches the clock. In master role the sum covers one byte segment at a time. In slave role it covers a whole message.

All counts advance on a prescaled tick, set by the `TICK_DIV` parameter. Every limit is a 16-bit tick count, and a limit of zero turns its check off. Each timeout sets a sticky flag, which software clears by writing one to that flag's bit. The interrupt request comes from the low-timeout summary flag and from the stuck-bus flag. All pins are plain control and status pins. The block has no data stream, so it has no valid/ready handshake and no back-pressure.

Flag bit positions in `flags_o` and `flag_clr_i`: bit 0 idle, bit 1 stuck, bit 2 master extension, bit 3 slave extension, bit 4 low-timeout summary, bit 5 busy-while-idle error.

Top module: `smbus_timeout_mon`

## Requirements
- R1: When SCL and SDA are both high for `idle_lim_i` consecutive ticks, flag bit 0 is set and is visible after the edge that closes the last of those ticks. After one tick fewer, it is still clear.
- R2: One cycle that breaks the measured line condition restarts the idle count or the stuck count from zero.
- R3: When SCL is high and SDA is low for `stuck_lim_i` consecutive ticks, flag bit 1 is set.
- R4: When `busy_i` is high while flag bit 0 is set, flag bit 5 is set. When `busy_i` is low, bit 5 is not set.
- R5: In master role (`master_i`=1) with `mext_en_i`=1, ticks with `scl_hold_i` high are summed. A sum greater than `mext_lim_i` (the sum reaching limit+1) sets flag bit 2 and flag bit 4. The hold cycles do not need to be consecutive.
- R6: The master sum restarts at every START, ACK or STOP strobe. A strobe that arrives in the same cycle as a hold cycle clears the sum, and that hold cycle is not counted.
- R7: In slave role (`master_i`=0) with `sext_en_i`=1, hold ticks are summed from START until STOP, and ACK does not restart the sum. A sum greater than `sext_lim_i` sets flag bit 3 and flag bit 4. The master sum does not advance in slave role.
- R8: A cleared enable bit, or a limit of zero, keeps the matching check from setting any flag.
- R9: Flags stay set until a one is written to their bit of `flag_clr_i`. A clear affects only its own bit. A clear that arrives in the same cycle as a new set leaves the flag set.
- R10: `irq_o` is high when `irq_en_i` is 1 and flag bit 4 or flag bit 1 is set. It follows `irq_en_i` in the same cycle.
- R11: After reset, all flags and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| start_i | input | 1 | START event strobe |
| stop_i | input | 1 | STOP event strobe |
| ack_i | input | 1 | ACK event strobe (end of byte) |
| master_i | input | 1 | 1 = master role, 0 = slave role |
| busy_i | input | 1 | Controller busy status |
| scl_hold_i | input | 1 | This node is holding SCL low to stretch the clock |
| idle_lim_i | input | 16 | Idle timeout limit in ticks, 0 = off |
| stuck_lim_i | input | 16 | Stuck timeout limit in ticks, 0 = off |
| mext_lim_i | input | 16 | Master extension limit, 0 = off |
| sext_lim_i | input | 16 | Slave extension limit, 0 = off |
| mext_en_i | input | 1 | Enable for the master extension check |
| sext_en_i | input | 1 | Enable for the slave extension check |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 6 | Write-one-to-clear strobes, one per flag |
| flags_o | output | 6 | Sticky flags |
| irq_o | output | 1 | Interrupt request |

## Verification
A write-one clear can arrive in the same cycle as a new set of that same flag. This collision is provoked in two ways. First, the busy-while-idle flag is cleared while `busy_i` stays high, so its set condition repeats every cycle. Second, the stuck flag is cleared in the exact tick in which its count reaches the limit again after a one-cycle break. In both cases the flag must still read one on the next cycle. A second collision happens when a segment-boundary strobe and a hold cycle fall in the same cycle. It is judged by counting how many further hold cycles are needed before the master flag rises.

// File: rtl/stm_pkg.sv
package stm_pkg;
  localparam int FLAG_W   = 6;
  localparam int F_IDLE   = 0;
  localparam int F_STUCK  = 1;
  localparam int F_MEXT   = 2;
  localparam int F_SEXT   = 3;
  localparam int F_LOW    = 4;
  localparam int F_BUSYTO = 5;
  typedef logic [FLAG_W-1:0] flag_vec_t;
endpackage

// File: rtl/stm_flag.sv
module stm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R9: sticky until cleared
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o);
  // R9: set beats clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
endmodule

// File: rtl/stm_line_timer.sv
module stm_line_timer #(
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             cond_i,
  input  logic [LIM_W-1:0] lim_i,
  output logic             hit_o
);
  logic [LIM_W-1:0] cnt;
  logic             armed;

  assign armed = (lim_i != '0);
  assign hit_o = armed && cond_i && tick_i && (cnt == lim_i - LIM_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                cnt <= '0;
    else if (!cond_i)                          cnt <= '0;
    else if (tick_i && armed && cnt != lim_i)  cnt <= cnt + LIM_W'(1);
  end

  // R2: one broken cycle restarts the count
  a_r2_break: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_i |=> (cnt == '0));
endmodule

// File: rtl/stm_ext_accum.sv
module stm_ext_accum #(
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             active_i,
  input  logic             hold_i,
  input  logic             restart_i,
  input  logic [LIM_W-1:0] lim_i,
  output logic             hit_o
);
  localparam int SW = LIM_W + 1;

  logic [SW-1:0] sum;
  logic [SW-1:0] lim_x;
  logic          step;

  assign lim_x = {1'b0, lim_i};
  assign step  = active_i && (lim_i != '0) && tick_i && hold_i && !restart_i;
  assign hit_o = step && (sum == lim_x);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  sum <= '0;
    else if (restart_i)                          sum <= '0;
    else if (step && sum != lim_x + SW'(1))      sum <= sum + SW'(1);
  end

  // R6: segment boundary clears the running sum
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (sum == '0));
endmodule

// File: rtl/smbus_timeout_mon.sv
module smbus_timeout_mon
  import stm_pkg::*;
#(
  parameter int LIM_W    = 16,
  parameter int TICK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              ack_i,
  input  logic              master_i,
  input  logic              busy_i,
  input  logic              scl_hold_i,
  input  logic [LIM_W-1:0]  idle_lim_i,
  input  logic [LIM_W-1:0]  stuck_lim_i,
  input  logic [LIM_W-1:0]  mext_lim_i,
  input  logic [LIM_W-1:0]  sext_lim_i,
  input  logic              mext_en_i,
  input  logic              sext_en_i,
  input  logic              irq_en_i,
  input  logic [FLAG_W-1:0] flag_clr_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o
);
  logic      tick;
  logic      idle_hit, stuck_hit, m_hit, s_hit;
  flag_vec_t set_v;

  generate
    if (TICK_DIV <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(TICK_DIV);
      logic [PW-1:0] pc;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        pc <= '0;
        else if (pc == PW'(TICK_DIV - 1))  pc <= '0;
        else                               pc <= pc + PW'(1);
      end
      assign tick = (pc == PW'(TICK_DIV - 1));
    end
  endgenerate

  stm_line_timer #(.LIM_W(LIM_W)) u_idle (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .cond_i(scl_i && sda_i), .lim_i(idle_lim_i), .hit_o(idle_hit));

  stm_line_timer #(.LIM_W(LIM_W)) u_stuck (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .cond_i(scl_i && !sda_i), .lim_i(stuck_lim_i), .hit_o(stuck_hit));

  stm_ext_accum #(.LIM_W(LIM_W)) u_mext (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .active_i(master_i && mext_en_i), .hold_i(scl_hold_i),
    .restart_i(start_i || ack_i || stop_i),
    .lim_i(mext_lim_i), .hit_o(m_hit));

  stm_ext_accum #(.LIM_W(LIM_W)) u_sext (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .active_i(!master_i && sext_en_i), .hold_i(scl_hold_i),
    .restart_i(start_i || stop_i),
    .lim_i(sext_lim_i), .hit_o(s_hit));

  always_comb begin
    set_v           = '0;
    set_v[F_IDLE]   = idle_hit;
    set_v[F_STUCK]  = stuck_hit;
    set_v[F_MEXT]   = m_hit;
    set_v[F_SEXT]   = s_hit;
    set_v[F_LOW]    = m_hit || s_hit;
    set_v[F_BUSYTO] = busy_i && flags_o[F_IDLE];
  end

  generate
    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
      stm_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_i(set_v[i]),
        .clr_i(flag_clr_i[i]), .q_o(flags_o[i]));
    end
  endgenerate

  assign irq_o = irq_en_i && (flags_o[F_LOW] || flags_o[F_STUCK]);

  // R1: idle flag only rises after both lines were high
  a_r1_idle_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_o[F_IDLE]) |-> $past(scl_i && sda_i));
  // R4: error flag only rises after busy while idle
  a_r4_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_o[F_BUSYTO]) |-> $past(busy_i && flags_o[F_IDLE]));
  // R5: summary low flag only rises with an extension hit
  a_r5_low_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_o[F_LOW]) |-> $past(m_hit || s_hit));
endmodule

// File: tb/test_smbus_timeout_mon.sv
module test_smbus_timeout_mon;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b0, sda = 1'b0, start = 1'b0, stop = 1'b0, ack = 1'b0;
  logic        master = 1'b0, busy = 1'b0, hold = 1'b0;
  logic [15:0] idle_lim = '0, stuck_lim = '0, mext_lim = '0, sext_lim = '0;
  logic        mext_en = 1'b0, sext_en = 1'b0, irq_en = 1'b0;
  logic [5:0]  clr = '0;
  logic [5:0]  flags;
  logic        irq;
  int          n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  smbus_timeout_mon #(.LIM_W(16), .TICK_DIV(1)) i_smbus_timeout_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .start_i(start),
    .stop_i(stop), .ack_i(ack), .master_i(master), .busy_i(busy),
    .scl_hold_i(hold), .idle_lim_i(idle_lim), .stuck_lim_i(stuck_lim),
    .mext_lim_i(mext_lim), .sext_lim_i(sext_lim), .mext_en_i(mext_en),
    .sext_en_i(sext_en), .irq_en_i(irq_en), .flag_clr_i(clr),
    .flags_o(flags), .irq_o(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    clr = 6'h3F; step(1); clr = '0;
  endtask

  task automatic hold_for(input int n);
    hold = 1'b1; step(n); hold = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 flags", 32'(flags), 0);
    chk("R11 irq", 32'(irq), 0);
  endtask

  task automatic t_idle();
    idle_lim = 16'd6; stuck_lim = 16'd0;
    scl = 1'b1; sda = 1'b1;
    step(5); chk("R1 one tick short", 32'(flags[0]), 0);
    step(1); chk("R1 idle set", 32'(flags[0]), 1);
    chk("R4 no busy no error", 32'(flags[5]), 0);
    scl = 1'b0; clear_all();
    scl = 1'b1; step(4);
    sda = 1'b0; step(1); sda = 1'b1;      // one broken cycle
    step(5); chk("R2 restart after break", 32'(flags[0]), 0);
    chk("R8 zero stuck limit off", 32'(flags[1]), 0);
    step(1); chk("R2 idle after full run", 32'(flags[0]), 1);
  endtask

  task automatic t_busy();
    busy = 1'b1; step(1);
    chk("R4 busy while idle", 32'(flags[5]), 1);
    clr = 6'h20; step(1); clr = '0;
    chk("R9 set beats clear", 32'(flags[5]), 1);
    busy = 1'b0; clr = 6'h20; step(1); clr = '0;
    chk("R9 clear own bit", 32'(flags[5]), 0);
    chk("R9 other bit kept", 32'(flags[0]), 1);
    clear_all(); step(2);
    chk("R1 no re-set in same run", 32'(flags[0]), 0);
    scl = 1'b0; sda = 1'b0; idle_lim = '0;
  endtask

  task automatic t_stuck();
    stuck_lim = 16'd5; irq_en = 1'b1;
    scl = 1'b1; sda = 1'b0;
    step(4); chk("R3 one tick short", 32'(flags[1]), 0);
    chk("R10 no irq yet", 32'(irq), 0);
    step(1); chk("R3 stuck set", 32'(flags[1]), 1);
    chk("R10 irq from stuck", 32'(irq), 1);
    irq_en = 1'b0; #1;
    chk("R10 irq masked", 32'(irq), 0);
    scl = 1'b0; step(1); scl = 1'b1;
    step(4); clr = 6'h02; step(1); clr = '0;
    chk("R9 clear in hit tick", 32'(flags[1]), 1);
    scl = 1'b0; clear_all();
    chk("R9 cleared", 32'(flags[1]), 0);
    stuck_lim = '0;
  endtask

  task automatic t_mext();
    master = 1'b1; mext_en = 1'b1; mext_lim = 16'd5;
    start = 1'b1; step(1); start = 1'b0;
    hold_for(3); step(2); hold_for(2);
    chk("R5 sum at limit no flag", 32'(flags[2]), 0);
    ack = 1'b1; step(1); ack = 1'b0;
    hold_for(5); chk("R6 ack restarts", 32'(flags[2]), 0);
    hold_for(1); chk("R5 mext set", 32'(flags[2]), 1);
    chk("R5 low set", 32'(flags[4]), 1);
    chk("R7 sext untouched", 32'(flags[3]), 0);
    irq_en = 1'b1; #1; chk("R10 irq from low", 32'(irq), 1);
    irq_en = 1'b0;
    stop = 1'b1; step(1); stop = 1'b0; clear_all();
    hold_for(5); hold = 1'b1; ack = 1'b1; step(1); ack = 1'b0;
    step(5); hold = 1'b0;
    chk("R6 strobe with hold not counted", 32'(flags[2]), 0);
    hold_for(1); chk("R6 flag after full segment", 32'(flags[2]), 1);
    stop = 1'b1; step(1); stop = 1'b0; clear_all();
    mext_en = 1'b0; hold_for(8);
    chk("R8 enable off", 32'(flags[2]), 0);
    mext_en = 1'b1; mext_lim = '0; hold_for(8);
    chk("R8 zero limit off", 32'(flags[4:2]), 0);
  endtask

  task automatic t_sext();
    master = 1'b0; sext_en = 1'b1; sext_lim = 16'd4; mext_lim = 16'd1;
    start = 1'b1; step(1); start = 1'b0;
    hold_for(2); ack = 1'b1; step(1); ack = 1'b0; hold_for(2);
    chk("R7 ack does not restart, at limit", 32'(flags[3]), 0);
    hold_for(1); chk("R7 sext set", 32'(flags[3]), 1);
    chk("R7 low set", 32'(flags[4]), 1);
    chk("R7 master sum idle in slave role", 32'(flags[2]), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(3); t_reset();
    rst_n = 1'b1; step(1); t_reset();
    t_idle();
    t_busy();
    t_stuck();
    t_mext();
    t_sext();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule